// File: doc/BRIEF.md
# Masked Vector Lane Expand Unit

The unit takes a packed source vector, a merge vector and a lane mask. It places the lowest source elements, in their original order, into the output lanes whose mask bit is set. The first source element goes to the lowest selected lane, the second to the next selected lane above it, and so on. Every output lane whose mask bit is clear is filled from the same lane of the merge vector. When the zero-fill input is high, those lanes are cleared instead. Lanes are handled as raw 64-bit patterns, with no numeric meaning.

The lane count is a parameter (default 8). The mask input is always 8 bits wide, and only its low bits that map to real lanes are used. Each operation is presented with an input valid strobe. The result is registered and appears one clock later, together with an output valid strobe.

Top module: `masked_lane_expand`

## Requirements
- R1: For an output lane i whose mask bit is set, the result lane equals the source element whose index is the number of set mask bits in lanes 0 to i-1. Lane 0 is the least significant 64 bits of each vector, and mask bit i selects lane i.
- R2: With zeroMode low, an output lane whose mask bit is clear equals the merge vector lane at the same index.
- R3: With zeroMode high, an output lane whose mask bit is clear is all zeros.
- R4: Mask bits at positions equal to or above the lane count have no effect on the result.
- R5: Source elements at indices equal to or above the number of set mask bits have no effect on the result.
- R6: An all-zero mask gives a result equal to the merge vector, or all zeros when zeroMode is high.
- R7: outValid in a cycle equals inValid in the previous cycle. The result register loads only on a cycle with inValid high and otherwise holds its value.
- R8: While reset is asserted, outValid is 0 and the result is all zeros.
- R9: With six lanes, zeroMode high, mask bits 1, 2 and 4 set, and source elements 2, 3 and 4, the result lanes from lane 0 upward are 0, 2, 3, 0, 4, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands are valid this cycle |
| srcVec | input | LANES*64 | Packed source elements, lane 0 in the low bits |
| mergeVec | input | LANES*64 | Fill values for lanes whose mask bit is clear |
| laneMask | input | 8 | Lane select mask, bit i selects lane i |
| zeroMode | input | 1 | Clear unselected lanes instead of merging |
| outValid | output | 1 | Result is valid, one clock after inValid |
| resVec | output | LANES*64 | Registered expanded result |

## Verification
The bench builds two instances. One uses the default eight lanes, where every mask bit is live and the whole range of prefix counts is reached. The other uses six lanes, which leaves two mask bits with no lane. This lets the bench show that those bits are ignored, and it lets it run the six-lane zeroing example exactly. Both instances get the same random and directed operands: empty, full and single-bit masks, junk in the unused source lanes, and idle cycles with changing inputs.

// File: rtl/lane_expand_pkg.sv
package lane_expand_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load result register this cycle
    logic zeroFill;  // unselected lanes become zero
  } lexpStrobe_t;

  localparam int ELEM_W = 64;
  localparam int MASK_W = 8;
endpackage

// File: rtl/lexp_ctrl.sv
module lexp_ctrl
  import lane_expand_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        zeroMode,
  output lexpStrobe_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.capture  = inValid;
    strobes.zeroFill = zeroMode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R7: valid latency of one clock
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
endmodule

// File: rtl/lexp_datapath.sv
module lexp_datapath
  import lane_expand_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  lexpStrobe_t             strobes,
  input  logic [LANES*ELEM_W-1:0] srcVec,
  input  logic [LANES*ELEM_W-1:0] mergeVec,
  input  logic [MASK_W-1:0]       laneMask,
  output logic [LANES*ELEM_W-1:0] resVec
);
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int VEC_W = LANES * ELEM_W;

  logic [LANES-1:0]  usedMask;
  logic [ELEM_W-1:0] srcLane   [LANES];
  logic [CNT_W-1:0]  rank      [LANES];
  logic [VEC_W-1:0]  nextRes;

  // R4: only the mask bits backed by a lane take part
  assign usedMask = laneMask[LANES-1:0];

  generate
    if (MASK_W > LANES) begin : g_spareBits
      logic [MASK_W-LANES-1:0] spareBits;
      assign spareBits = laneMask[MASK_W-1:LANES];
      logic unusedSpare;
      assign unusedSpare = ^spareBits;
    end
  endgenerate

  // Prefix popcount chain: rank[i] = set bits below lane i
  assign rank[0] = '0;
  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign srcLane[gi] = srcVec[gi*ELEM_W +: ELEM_W];
      if (gi > 0) begin : g_rank
        assign rank[gi] = rank[gi-1] + CNT_W'(usedMask[gi-1]);
      end

      logic [ELEM_W-1:0] picked;
      always_comb begin
        picked = '0;
        for (int j = 0; j < LANES; j++) begin
          if (rank[gi] == CNT_W'(j)) picked = srcLane[j];
        end
      end

      always_comb begin
        if (usedMask[gi])          nextRes[gi*ELEM_W +: ELEM_W] = picked;
        else if (strobes.zeroFill) nextRes[gi*ELEM_W +: ELEM_W] = '0;
        else                       nextRes[gi*ELEM_W +: ELEM_W] = mergeVec[gi*ELEM_W +: ELEM_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)               resVec <= '0;
    else if (strobes.capture) resVec <= nextRes;
  end

  // R7: hold when no operation is presented
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.capture |=> $stable(resVec));
  // R6: empty mask, zeroing mode
  a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && usedMask == '0 && strobes.zeroFill) |=> resVec == '0);
  // R6: empty mask, merge mode
  a_r6_empty_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && usedMask == '0 && !strobes.zeroFill) |=> resVec == $past(mergeVec));
  // R1: lowest selected lane always receives source element 0
  a_r1_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && usedMask[0]) |=> resVec[ELEM_W-1:0] == $past(srcVec[ELEM_W-1:0]));
  // R3: unselected lane 0 in zeroing mode is cleared
  a_r3_lane0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.capture && !usedMask[0] && strobes.zeroFill) |=> resVec[ELEM_W-1:0] == '0);
endmodule

// File: rtl/masked_lane_expand.sv
module masked_lane_expand
  import lane_expand_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic [LANES*64-1:0]     srcVec,
  input  logic [LANES*64-1:0]     mergeVec,
  input  logic [7:0]              laneMask,
  input  logic                    zeroMode,
  output logic                    outValid,
  output logic [LANES*64-1:0]     resVec
);
  lexpStrobe_t strobes;

  lexp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .zeroMode (zeroMode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lexp_datapath #(.LANES(LANES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .srcVec   (srcVec),
    .mergeVec (mergeVec),
    .laneMask (laneMask),
    .resVec   (resVec)
  );
endmodule

// File: tb/masked_lane_expand_tb.sv
module masked_lane_expand_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic [511:0] src = '0;
  logic [511:0] mrg = '0;
  logic [7:0] mask = '0;
  logic zero = 1'b0;
  logic outValid8, outValid6;
  logic [511:0] res8;
  logic [383:0] res6;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  masked_lane_expand #(.LANES(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .srcVec(src), .mergeVec(mrg),
    .laneMask(mask), .zeroMode(zero), .outValid(outValid8), .resVec(res8));

  masked_lane_expand #(.LANES(6)) u_dut6 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .srcVec(src[383:0]), .mergeVec(mrg[383:0]),
    .laneMask(mask), .zeroMode(zero), .outValid(outValid6), .resVec(res6));

  function automatic logic [511:0] refExpand(int n, logic [511:0] s, logic [511:0] m,
                                             logic [7:0] k, logic z);
    logic [511:0] r = '0;
    int pos = 0;
    for (int i = 0; i < n; i++) begin
      if (k[i]) begin
        r[i*64 +: 64] = s[pos*64 +: 64];
        pos++;
      end else begin
        r[i*64 +: 64] = z ? 64'd0 : m[i*64 +: 64];
      end
    end
    return r;
  endfunction

  task automatic check(string req, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one operation, then check both instances after the capture edge
  task automatic runOp(string req, logic [511:0] s, logic [511:0] m, logic [7:0] k, logic z);
    @(negedge clk);
    src = s; mrg = m; mask = k; zero = z; inValid = 1'b1;
    @(negedge clk);
    check({req, " valid8"}, {511'd0, outValid8}, 512'd1);
    check({req, " lanes8"}, res8, refExpand(8, s, m, k, z));
    check({req, " lanes6"}, {128'd0, res6}, refExpand(6, s, m, k, z));
    inValid = 1'b0;
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [511:0] s, m, held8;
    logic [383:0] held6;
    logic [7:0] k;
    int unsigned seed = 32'h5EED_0042;
    void'($urandom(seed));

    // R8: reset state
    src = rnd512(); mrg = rnd512(); mask = 8'hFF; inValid = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 valid", {510'd0, outValid8, outValid6}, 512'd0);
    check("R8 res8", res8, 512'd0);
    check("R8 res6", {128'd0, res6}, 512'd0);
    inValid = 1'b0;
    rst_n = 1'b1;

    // R9: six-lane zeroing example, spare mask bits set as well (R4)
    s = rnd512();
    s[63:0] = 64'd2; s[127:64] = 64'd3; s[191:128] = 64'd4;
    m = rnd512();
    runOp("R9", s, m, 8'b1101_0110, 1'b1);
    check("R9 exact", {128'd0, res6},
          {128'd0, 64'd0, 64'd4, 64'd0, 64'd3, 64'd2, 64'd0});
    // R4: changing spare bits leaves six-lane result unchanged
    runOp("R4 spare clear", s, m, 8'b0001_0110, 1'b1);
    check("R4 exact", {128'd0, res6},
          {128'd0, 64'd0, 64'd4, 64'd0, 64'd3, 64'd2, 64'd0});

    // R6: empty mask, both modes
    runOp("R6 merge", rnd512(), rnd512(), 8'h00, 1'b0);
    runOp("R6 zero", rnd512(), rnd512(), 8'h00, 1'b1);
    // R1: full mask copies source through
    runOp("R1 full", rnd512(), rnd512(), 8'hFF, 1'b0);
    // R1/R2: single top lane takes source element 0
    runOp("R1 top", rnd512(), rnd512(), 8'h80, 1'b0);
    runOp("R2 single", rnd512(), rnd512(), 8'h10, 1'b0);
    runOp("R3 single", rnd512(), rnd512(), 8'h21, 1'b1);

    // R5: junk in source lanes above popcount has no effect
    s = rnd512(); m = rnd512();
    runOp("R5 first", s, m, 8'b1010_0100, 1'b0);
    held8 = res8;
    s[511:192] = ~s[511:192];
    runOp("R5 junk", s, m, 8'b1010_0100, 1'b0);
    check("R5 unchanged", res8, held8);

    // R7: idle cycle with changed inputs holds result
    held8 = res8; held6 = res6;
    @(negedge clk);
    src = rnd512(); mrg = rnd512(); mask = $urandom(); zero = ~zero;
    @(negedge clk);
    check("R7 idle valid", {510'd0, outValid8, outValid6}, 512'd0);
    check("R7 hold8", res8, held8);
    check("R7 hold6", {128'd0, res6}, {128'd0, held6});

    // Random operations covering R1 R2 R3, with idle gaps for R7
    for (int it = 0; it < 400; it++) begin
      k = $urandom();
      runOp("R1 R2 R3 random", rnd512(), rnd512(), k, 1'($urandom()));
      if (it % 5 == 0) begin
        held8 = res8;
        @(negedge clk);
        src = rnd512(); mask = $urandom();
        @(negedge clk);
        check("R7 gap", res8, held8);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule